// File: doc/BRIEF.md
# PCI Target Address and Command Decoder

This block sits behind a 32-bit PCI target core. In the cycle where the core flags an address phase, it classifies the bus command as a user read, a user write or neither. It also checks the address against a set of base address windows, each gated by its space-enable bit. It returns read-decode, write-decode and select to the core combinationally, within that same cycle. The block latches the address and the selection result at that point, because after the address phase the shared bus carries data.

During the burst the block holds a running dword address that steps by 4 on every completion pulse from the core. For writes it turns each completion pulse into a registered strobe, issued together with the data, the active-high lane enables and the dword address. It asks the core for wait states until a parameterised backend latency has elapsed after the address phase and after each transfer. It raises a stop request once the running address leaves the window that was hit.

Top module: `pci_tgt_decode`

## Requirements
- R1: On a clock edge with `adr_valid_i` high, `ad_i` is latched and appears on `cur_addr_o` after that edge. Later changes on `ad_i` do not alter it.
- R2: While `adr_valid_i` is high, `rd_decode_o` is 1 for the command codes on `cbe_i` of 0010 (I/O read), 0110 (memory read), 1100 (read multiple) and 1110 (read line), and 0 for every other code.
- R3: While `adr_valid_i` is high, `wr_decode_o` is 1 for the codes 0011 (I/O write), 0111 (memory write) and 1111 (write and invalidate), and 0 for every other code, including the configuration codes 1010 and 1011.
- R4: While `adr_valid_i` is low, `rd_decode_o`, `wr_decode_o` and `select_o` are 0, whatever is on `ad_i` and `cbe_i`.
- R5: `select_o` is 1 only when all of the following hold:
  - the command is a user read or user write;
  - the address lies in window i, meaning its bits above `BAR_LOG2[i]` equal those of base i;
  - the window is enabled, with memory windows gated by `mem_en_i` and I/O windows (bit i of `BAR_IS_IO` set) gated by `io_en_i`;
  - the command type matches the window type, where I/O commands have `cbe_i[3:1]`=001.
- R6: Each clock edge with `adr_inc_i` high and `adr_valid_i` low adds 4 to `cur_addr_o`.
- R7: An edge with `user_write_i` and `adr_inc_i` both high gives one cycle of `wr_strobe_o` after that edge. In that cycle `wr_data_o` is the captured `ad_i`, `wr_be_o` is the inverse of the captured `cbe_i`, and `wr_addr_o` is the running address before the step. This happens whatever the state of `rdy_o`. With `user_write_i` low, no strobe is issued.
- R8: During and after reset, `rdy_o`, `stop_o` and `wr_strobe_o` are 0 and `cur_addr_o` is 0.
- R9: After a selected address phase, and after each increment pulse, `rdy_o` is 0 for `LATENCY` cycles and then 1. For an unselected transaction, `rdy_o` stays 0.
- R10: `stop_o` is 1 while the transaction is selected and `cur_addr_o` lies outside the window hit in the address phase.
- R11: An edge with `xfer_end_i` high ends the transaction. After that edge, `rdy_o` and `stop_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adr_valid_i | input | 1 | Address phase flag from the core |
| adr_inc_i | input | 1 | Transfer completed pulse |
| ad_i | input | 32 | Registered address / write data bus |
| cbe_i | input | 4 | Command (address phase) or active-low byte enables |
| user_write_i | input | 1 | User write transaction active level |
| xfer_end_i | input | 1 | Pulse one cycle after the last data phase |
| bar_base_i | input | 32*NUM_BARS | Base address per window, window i in bits [32i+31:32i] |
| mem_en_i | input | 1 | Memory space enable |
| io_en_i | input | 1 | I/O space enable |
| rd_decode_o | output | 1 | User read command decoded |
| wr_decode_o | output | 1 | User write command decoded |
| select_o | output | 1 | Address hits an enabled window |
| cur_addr_o | output | 32 | Running dword address |
| rdy_o | output | 1 | Backend ready; low inserts wait states |
| stop_o | output | 1 | Request to stop the burst |
| wr_strobe_o | output | 1 | Per-dword write strobe |
| wr_addr_o | output | 32 | Address of the strobed dword |
| wr_data_o | output | 32 | Strobed write data |
| wr_be_o | output | 4 | Active-high lane enables of the strobed dword |

## Verification
The decoder is swept over all sixteen command codes, which separates the read class, the write class and the non-user codes such as configuration accesses. Select is tried with:
- hits in a memory window and in an I/O window;
- each space enable cleared;
- an I/O command aimed at a memory window;
- an address one byte past a window.

Together these tell the enable gating apart from the address compare and the type match. Bursts are run in three forms:
- one that crosses a window end, to place the stop request;
- one with writes during wait states, to show that strobes ignore ready;
- one with the write level low, to show that no strobe is issued.

// File: rtl/pci_dec_pkg.sv
package pci_dec_pkg;
  typedef enum logic [3:0] {
    CMD_IO_RD   = 4'b0010,
    CMD_IO_WR   = 4'b0011,
    CMD_MEM_RD  = 4'b0110,
    CMD_MEM_WR  = 4'b0111,
    CMD_MEM_RDM = 4'b1100,
    CMD_MEM_RDL = 4'b1110,
    CMD_MEM_WRI = 4'b1111
  } cmd_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic io;
  } cmd_class_t;
endpackage

// File: rtl/pci_cmd_class.sv
module pci_cmd_class
  import pci_dec_pkg::*;
(
  input  logic [3:0] cmd_i,
  output cmd_class_t cls_o
);
  always_comb begin
    cls_o    = '0;
    cls_o.io = (cmd_i[3:1] == 3'b001);
    case (cmd_i)
      CMD_IO_RD, CMD_MEM_RD, CMD_MEM_RDM, CMD_MEM_RDL: cls_o.rd = 1'b1;
      CMD_IO_WR, CMD_MEM_WR, CMD_MEM_WRI:              cls_o.wr = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pci_bar_match.sv
module pci_bar_match #(
  parameter int                          NUM_BARS  = 2,
  parameter logic [NUM_BARS-1:0][4:0]    BAR_LOG2  = {5'd4, 5'd8},
  parameter logic [NUM_BARS-1:0]         BAR_IS_IO = 2'b10
) (
  input  logic [31:0]                addr_i,
  input  logic [NUM_BARS-1:0][31:0]  bar_base_i,
  input  logic                       mem_en_i,
  input  logic                       io_en_i,
  input  logic                       is_io_i,
  output logic                       any_hit_o,
  output logic [31:0]                win_base_o,
  output logic [31:0]                win_mask_o
);
  logic [NUM_BARS-1:0]       hit;
  logic [NUM_BARS-1:0][31:0] mask;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam logic [31:0] MASK = ~((32'h1 << BAR_LOG2[i]) - 32'h1);
    logic space_ok;
    if (BAR_IS_IO[i]) begin : g_io
      assign space_ok = io_en_i & is_io_i;
    end else begin : g_mem
      assign space_ok = mem_en_i & ~is_io_i;
    end
    assign mask[i] = MASK;
    assign hit[i]  = space_ok && ((addr_i & MASK) == (bar_base_i[i] & MASK));
  end

  // lowest index wins on overlap
  always_comb begin
    win_base_o = '0;
    win_mask_o = '0;
    for (int i = NUM_BARS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_base_o = bar_base_i[i] & mask[i];
        win_mask_o = mask[i];
      end
    end
  end

  assign any_hit_o = |hit;
endmodule

// File: rtl/pci_burst_ctr.sv
module pci_burst_ctr #(
  parameter int LATENCY = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] addr_i,
  input  logic        sel_i,
  input  logic [31:0] win_base_i,
  input  logic [31:0] win_mask_i,
  input  logic        inc_i,
  input  logic        end_i,
  output logic [31:0] addr_o,
  output logic        rdy_o,
  output logic        stop_o
);
  localparam int CW = (LATENCY > 0) ? $clog2(LATENCY + 1) : 1;
  localparam logic [CW-1:0] LAT = CW'(LATENCY);

  logic [31:0]   addr_q, wbase_q, wmask_q;
  logic          sel_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wbase_q <= '0;
      wmask_q <= '0;
      sel_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (load_i) begin
      addr_q  <= addr_i;
      wbase_q <= win_base_i;
      wmask_q <= win_mask_i;
      sel_q   <= sel_i;
      cnt_q   <= LAT;
    end else begin
      if (end_i) sel_q <= 1'b0;
      if (inc_i) begin
        addr_q <= addr_q + 32'd4;
        cnt_q  <= LAT;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign addr_o = addr_q;
  assign rdy_o  = sel_q && (cnt_q == '0);
  assign stop_o = sel_q && ((addr_q & wmask_q) != wbase_q);
endmodule

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_dec_pkg::*;
#(
  parameter int                       NUM_BARS  = 2,
  parameter logic [NUM_BARS-1:0][4:0] BAR_LOG2  = {5'd4, 5'd8},
  parameter logic [NUM_BARS-1:0]      BAR_IS_IO = 2'b10,
  parameter int                       LATENCY   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      adr_valid_i,
  input  logic                      adr_inc_i,
  input  logic [31:0]               ad_i,
  input  logic [3:0]                cbe_i,
  input  logic                      user_write_i,
  input  logic                      xfer_end_i,
  input  logic [NUM_BARS-1:0][31:0] bar_base_i,
  input  logic                      mem_en_i,
  input  logic                      io_en_i,
  output logic                      rd_decode_o,
  output logic                      wr_decode_o,
  output logic                      select_o,
  output logic [31:0]               cur_addr_o,
  output logic                      rdy_o,
  output logic                      stop_o,
  output logic                      wr_strobe_o,
  output logic [31:0]               wr_addr_o,
  output logic [31:0]               wr_data_o,
  output logic [3:0]                wr_be_o
);
  cmd_class_t  cls;
  logic        any_hit;
  logic [31:0] win_base, win_mask;

  pci_cmd_class u_cls (
    .cmd_i (cbe_i),
    .cls_o (cls)
  );

  pci_bar_match #(
    .NUM_BARS  (NUM_BARS),
    .BAR_LOG2  (BAR_LOG2),
    .BAR_IS_IO (BAR_IS_IO)
  ) u_bar (
    .addr_i     (ad_i),
    .bar_base_i (bar_base_i),
    .mem_en_i   (mem_en_i),
    .io_en_i    (io_en_i),
    .is_io_i    (cls.io),
    .any_hit_o  (any_hit),
    .win_base_o (win_base),
    .win_mask_o (win_mask)
  );

  assign rd_decode_o = adr_valid_i & cls.rd;
  assign wr_decode_o = adr_valid_i & cls.wr;
  assign select_o    = adr_valid_i & any_hit & (cls.rd | cls.wr);

  pci_burst_ctr #(.LATENCY(LATENCY)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (adr_valid_i),
    .addr_i     (ad_i),
    .sel_i      (select_o),
    .win_base_i (win_base),
    .win_mask_i (win_mask),
    .inc_i      (adr_inc_i),
    .end_i      (xfer_end_i),
    .addr_o     (cur_addr_o),
    .rdy_o      (rdy_o),
    .stop_o     (stop_o)
  );

  // write capture: taken on every completion, independent of rdy_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_strobe_o <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_be_o     <= '0;
    end else begin
      wr_strobe_o <= user_write_i & adr_inc_i & ~adr_valid_i;
      if (user_write_i & adr_inc_i & ~adr_valid_i) begin
        wr_addr_o <= cur_addr_o;
        wr_data_o <= ad_i;
        wr_be_o   <= ~cbe_i;
      end
    end
  end
endmodule

// File: rtl/pci_tgt_decode_chk.sv
module pci_tgt_decode_chk #(
  parameter int LATENCY = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        adr_valid_i,
  input logic        adr_inc_i,
  input logic [31:0] ad_i,
  input logic        user_write_i,
  input logic        xfer_end_i,
  input logic        rd_decode_o,
  input logic        wr_decode_o,
  input logic        select_o,
  input logic [31:0] cur_addr_o,
  input logic        rdy_o,
  input logic        stop_o,
  input logic        wr_strobe_o
);
  AST_DEC_ONLY_AV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adr_valid_i |-> !rd_decode_o && !wr_decode_o && !select_o); // R4

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_decode_o && wr_decode_o)); // R2

  AST_SEL_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    select_o |-> rd_decode_o || wr_decode_o); // R5

  AST_ADDR_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adr_valid_i |=> cur_addr_o == $past(ad_i)); // R1

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adr_inc_i && !adr_valid_i |=> cur_addr_o == $past(cur_addr_o) + 32'd4); // R6

  AST_STB_ON_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_write_i && adr_inc_i && !adr_valid_i |=> wr_strobe_o); // R7

  AST_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(user_write_i && adr_inc_i) |=> !wr_strobe_o); // R7

  AST_WAIT_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LATENCY > 0) && adr_valid_i |=> !rdy_o); // R9

  AST_END_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_i && !adr_valid_i |=> !rdy_o && !stop_o); // R11
endmodule

bind pci_tgt_decode pci_tgt_decode_chk #(.LATENCY(LATENCY)) u_chk (.*);

// File: tb/tb_pci_tgt_decode.sv
module tb_pci_tgt_decode;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             adr_valid = 0, adr_inc = 0, user_write = 0, xfer_end = 0;
  logic [31:0]      ad = '0;
  logic [3:0]       cbe = '0;
  logic [1:0][31:0] bar_base;
  logic             mem_en = 1, io_en = 1;
  logic             rd_dec, wr_dec, sel, rdy, stop, wstb;
  logic [31:0]      cur_addr, waddr, wdata;
  logic [3:0]       wbe;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bar_base[0] = 32'h1000_0000; // memory, 256 bytes
  assign bar_base[1] = 32'h0000_C000; // I/O, 16 bytes

  pci_tgt_decode dut (
    .clk_i(clk), .rst_ni(rst_n), .adr_valid_i(adr_valid), .adr_inc_i(adr_inc),
    .ad_i(ad), .cbe_i(cbe), .user_write_i(user_write), .xfer_end_i(xfer_end),
    .bar_base_i(bar_base), .mem_en_i(mem_en), .io_en_i(io_en),
    .rd_decode_o(rd_dec), .wr_decode_o(wr_dec), .select_o(sel),
    .cur_addr_o(cur_addr), .rdy_o(rdy), .stop_o(stop), .wr_strobe_o(wstb),
    .wr_addr_o(waddr), .wr_data_o(wdata), .wr_be_o(wbe)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // address phase driven at negedge, comb outputs checked mid-cycle
  task automatic addr_phase(logic [31:0] a, logic [3:0] c, logic exp_sel);
    adr_valid = 1; ad = a; cbe = c;
    #1 chk("R5 select", sel, exp_sel);
    tick();
    adr_valid = 0; ad = 32'hDEAD_BEEF; cbe = 4'h0;
  endtask

  task automatic inc_pulse(logic [31:0] d, logic [3:0] c);
    adr_inc = 1; ad = d; cbe = c;
    tick();
    adr_inc = 0; ad = 32'h5555_AAAA; cbe = 4'hF;
  endtask

  task automatic end_xfer();
    xfer_end = 1; tick(); xfer_end = 0;
  endtask

  task automatic t_reset();
    chk("R8 rdy", rdy, 0);
    chk("R8 stop", stop, 0);
    chk("R8 strobe", wstb, 0);
    chk("R8 addr", cur_addr, 0);
  endtask

  task automatic t_decode_sweep();
    for (int c = 0; c < 16; c++) begin
      adr_valid = 1; ad = 32'h0; cbe = 4'(c);
      #1;
      chk("R2 rd_decode", rd_dec, (c == 2 || c == 6 || c == 12 || c == 14));
      chk("R3 wr_decode", wr_dec, (c == 3 || c == 7 || c == 15));
      @(negedge clk);
    end
    adr_valid = 0;
    tick();
  endtask

  task automatic t_no_av();
    adr_valid = 0; ad = 32'h1000_0010; cbe = 4'b0110;
    #1;
    chk("R4 rd_decode", rd_dec, 0);
    chk("R4 select", sel, 0);
    cbe = 4'b0111; #1;
    chk("R4 wr_decode", wr_dec, 0);
    @(negedge clk);
  endtask

  task automatic t_select();
    addr_phase(32'h1000_0010, 4'b0110, 1); end_xfer();
    addr_phase(32'h1000_00FC, 4'b1111, 1); end_xfer();
    addr_phase(32'h1000_0100, 4'b0110, 0); end_xfer(); // one past window
    addr_phase(32'h1000_0010, 4'b0010, 0); end_xfer(); // I/O cmd at memory window
    addr_phase(32'h1000_0010, 4'b1010, 0); end_xfer(); // config read
    addr_phase(32'h0000_C004, 4'b0010, 1); end_xfer();
    addr_phase(32'h0000_C010, 4'b0011, 0); end_xfer();
    mem_en = 0;
    addr_phase(32'h1000_0010, 4'b0110, 0); end_xfer();
    mem_en = 1; io_en = 0;
    addr_phase(32'h0000_C004, 4'b0011, 0); end_xfer();
    io_en = 1;
  endtask

  task automatic t_burst_write();
    user_write = 1;
    addr_phase(32'h1000_0040, 4'b0111, 1);
    chk("R1 latch", cur_addr, 32'h1000_0040);
    chk("R9 wait1", rdy, 0);
    inc_pulse(32'h1111_2222, 4'b0101); // during wait state
    chk("R6 step", cur_addr, 32'h1000_0044);
    chk("R7 strobe", wstb, 1);
    chk("R7 data", wdata, 32'h1111_2222);
    chk("R7 be", wbe, 4'b1010);
    chk("R7 addr", waddr, 32'h1000_0040);
    chk("R9 wait after inc", rdy, 0);
    tick();
    chk("R7 one cycle", wstb, 0);
    chk("R9 wait2", rdy, 0);
    tick();
    chk("R9 ready", rdy, 1);
    inc_pulse(32'h3333_4444, 4'b0000);
    chk("R6 step2", cur_addr, 32'h1000_0048);
    chk("R7 be2", wbe, 4'b1111);
    chk("R7 addr2", waddr, 32'h1000_0044);
    user_write = 0;
    inc_pulse(32'h7777_8888, 4'b0000);
    chk("R7 no strobe", wstb, 0);
    chk("R7 data held", wdata, 32'h3333_4444);
    end_xfer();
    chk("R11 rdy", rdy, 0);
  endtask

  task automatic t_stop();
    addr_phase(32'h1000_00F8, 4'b0110, 1);
    chk("R10 stop in", stop, 0);
    inc_pulse(32'h0, 4'h0);
    chk("R10 stop last", stop, 0);
    inc_pulse(32'h0, 4'h0);
    chk("R6 cross", cur_addr, 32'h1000_0100);
    chk("R10 stop out", stop, 1);
    end_xfer();
    chk("R11 stop", stop, 0);
    chk("R11 rdy", rdy, 0);
  endtask

  task automatic t_unselected();
    addr_phase(32'h2000_0000, 4'b0110, 0);
    chk("R1 latch unsel", cur_addr, 32'h2000_0000);
    tick(); tick(); tick();
    chk("R9 unsel rdy", rdy, 0);
    chk("R10 unsel stop", stop, 0);
    end_xfer();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_decode_sweep();
    t_no_av();
    t_select();
    t_burst_write();
    t_stop();
    t_unselected();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule